// File: doc/BRIEF.md
# Packed Dual-Lane Dot Product Unit

This block computes the dot product of a coefficient vector and a sample vector, both made of 16-bit elements. Operands arrive two elements at a time: every 32-bit word carries element n in its lower halfword and element n+1 in its upper halfword. Two multiplier lanes work side by side, so each accepted word pair yields two products per cycle. The lower-half product is added into an even-term accumulator and the upper-half product into an odd-term accumulator. The two partial sums are joined only once the last pair has passed through.

A job begins with a one-cycle `start` that loads the pair count and latches two mode bits. `signed_mode` selects signed or unsigned multiplication. `ext_mode` selects 40-bit saturating accumulation; when it is clear, accumulation wraps at 32 bits. The feeder then presents word pairs with `op_valid`, and may leave gaps between them. Once the count is used up, the unit raises `done` for one cycle together with the full sum and its lower halfword, then holds both until the next job completes.

Top module: `dotp_unit`

## Requirements
- R1: While reset is held and directly after it, `done`, `busy` and `sat_flag` are 0 and `result` is 0.
- R2: For each accepted pair, the product of the lower halfwords (bits 15:0) is added to the even sum and the product of the upper halfwords (bits 31:16) to the odd sum. The final result is even sum plus odd sum.
- R3: `signed_mode`=1 multiplies halfwords as two's complement, 0 multiplies them as unsigned. The value is sampled on `start`.
- R4: A job accepts exactly `count` pairs. Words offered with `op_valid` after the last pair do not change `result`, do not raise `done` and leave `busy` low.
- R5: Cycles with `op_valid` low in the middle of a job change nothing; the result equals the one for a job without gaps.
- R6: `done` is high for exactly one cycle, on the second rising edge after the edge that accepts the last pair, with `busy` low.
- R7: A `start` with `count`=0 gives `done` on the second rising edge after `start`, with `result`=0.
- R8: `start` clears both sums and `sat_flag`, and a `start` during a running job abandons it; only the new job's pairs count.
- R9: With `ext_mode`=0, both sums and the final addition wrap modulo 2^32, and `result` is that 32-bit value sign-extended to 40 bits.
- R10: With `ext_mode`=1, the sums and the final addition are 40-bit two's complement and clamp to 2^39-1 or -2^39 on overflow. Any clamp sets `sat_flag`, which stays set until the next `start`.
- R11: `result_lo` always equals `result[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; loads count and modes |
| count | input | CNT_W (16) | Number of word pairs (N/2 for N terms) |
| signed_mode | input | 1 | 1: signed multiply, 0: unsigned |
| ext_mode | input | 1 | 1: 40-bit saturating, 0: 32-bit wrapping |
| op_valid | input | 1 | Coefficient and sample words are present |
| coef_word | input | 32 | Two packed coefficient halfwords |
| samp_word | input | 32 | Two packed sample halfwords |
| busy | output | 1 | Job still expects operand pairs |
| done | output | 1 | One-cycle pulse: result is ready |
| result | output | 40 | Final dot product |
| result_lo | output | 16 | Lower halfword of the result |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The unit has three registers between input and output. The edge that accepts a pair registers the products, the next edge adds them into the sums, and the edge after that registers the joined result and raises `done`. For a job of count zero, the same two-edge delay runs from `start`.

The bench drives inputs on falling edges and tracks falling edges after the last accepted pair. It expects `done` low on the first two and high on the third, and low again on the fourth. Every comparison of `result`, `result_lo` and `sat_flag` is taken on that third falling edge. Stuffed words and reset values are checked on the falling edges in between.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PROD_W = 2 * HALF_W;
  localparam int ACC_W  = 40;
  localparam int NLANE  = WORD_W / HALF_W;

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  typedef struct packed {
    logic             ovf;
    logic [ACC_W-1:0] sum;
  } sat_sum_t;

  // 16x16 multiply, signed or unsigned, 32-bit product
  function automatic logic [PROD_W-1:0] mul_half(input logic [HALF_W-1:0] a,
                                                  input logic [HALF_W-1:0] b,
                                                  input logic sgn);
    logic signed [HALF_W:0]     ax;
    logic signed [HALF_W:0]     bx;
    logic signed [2*HALF_W+1:0] r;
    ax = {sgn & a[HALF_W-1], a};
    bx = {sgn & b[HALF_W-1], b};
    r  = ax * bx;
    return r[PROD_W-1:0];
  endfunction

  // extend a product to accumulator width
  function automatic logic [ACC_W-1:0] widen(input logic [PROD_W-1:0] p, input logic sgn);
    return {{(ACC_W-PROD_W){sgn & p[PROD_W-1]}}, p};
  endfunction

  // 40-bit add with clamp to the rails
  function automatic sat_sum_t sat_add(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    sat_sum_t       r;
    s     = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    r.ovf = s[ACC_W] ^ s[ACC_W-1];
    r.sum = r.ovf ? (a[ACC_W-1] ? ACC_MIN : ACC_MAX) : s[ACC_W-1:0];
    return r;
  endfunction

  // 32-bit wrapping add, sign-extended to accumulator width
  function automatic logic [ACC_W-1:0] wrap_add(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
    logic [PROD_W-1:0] s;
    s = a[PROD_W-1:0] + b[PROD_W-1:0];
    return {{(ACC_W-PROD_W){s[PROD_W-1]}}, s};
  endfunction
endpackage

// File: rtl/dotp_lane_mul.sv
module dotp_lane_mul
  import dotp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  input  logic              sgn,
  output logic [PROD_W-1:0] prod_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prod_q <= '0;
    else if (load) prod_q <= mul_half(a, b, sgn);
  end
endmodule

// File: rtl/dotp_acc.sv
module dotp_acc
  import dotp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              ext,
  input  logic              sgn,
  input  logic [PROD_W-1:0] prod,
  output logic [ACC_W-1:0]  acc_q,
  output logic              sat_evt
);
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] acc_nxt;
  sat_sum_t         sa;

  always_comb begin
    addend  = widen(prod, sgn);
    sa      = sat_add(acc_q, addend);
    acc_nxt = ext ? sa.sum : wrap_add(acc_q, addend);
    sat_evt = en && !clr && ext && sa.ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (en)  acc_q <= acc_nxt;
  end

  // R8: idle accumulator keeps its value
  a_r8_acc_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(acc_q));
  // R8: clear empties the accumulator
  a_r8_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
  // R10: an overflow lands on a rail
  a_r10_clamp_rail: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> (acc_q == ACC_MAX || acc_q == ACC_MIN));
endmodule

// File: rtl/dotp_seq.sv
module dotp_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             op_valid,
  output logic             accept,
  output logic             acc_en,
  output logic             fin,
  output logic             busy
);
  logic [CNT_W-1:0] remain;
  logic             last_pair;
  logic             v1;
  logic             last1;

  assign accept    = busy && op_valid;
  assign last_pair = accept && (remain == CNT_W'(1));
  assign acc_en    = v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      v1     <= 1'b0;
      last1  <= 1'b0;
      fin    <= 1'b0;
    end else if (start) begin
      busy   <= (count != '0);
      remain <= count;
      v1     <= 1'b0;
      last1  <= 1'b0;
      fin    <= (count == '0);
    end else begin
      if (accept)    remain <= remain - CNT_W'(1);
      if (last_pair) busy   <= 1'b0;
      v1    <= accept;
      last1 <= last_pair;
      fin   <= v1 && last1;
    end
  end

  // R4: a busy job always has pairs left
  a_r4_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain != '0));
  // R6: the join happens with no pair still expected
  a_r6_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);
  // R6: the join is a single-cycle event
  a_r6_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !fin);
endmodule

// File: rtl/dotp_unit.sv
module dotp_unit
  import dotp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              signed_mode,
  input  logic              ext_mode,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] coef_word,
  input  logic [WORD_W-1:0] samp_word,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  result,
  output logic [HALF_W-1:0] result_lo,
  output logic              sat_flag
);
  logic              accept;
  logic              acc_en;
  logic              fin;
  logic              sgn_q;
  logic              ext_q;
  logic [PROD_W-1:0] prod [NLANE];
  logic [ACC_W-1:0]  acc  [NLANE];
  logic [NLANE-1:0]  lane_sat;
  sat_sum_t          join_sat;
  logic [ACC_W-1:0]  join_val;
  logic              join_ovf;

  dotp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count), .op_valid(op_valid),
    .accept(accept), .acc_en(acc_en), .fin(fin), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q <= 1'b0;
      ext_q <= 1'b0;
    end else if (start) begin
      sgn_q <= signed_mode;
      ext_q <= ext_mode;
    end
  end

  // lane 0: lower halfwords -> even sum; lane 1: upper halfwords -> odd sum
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    dotp_lane_mul u_mul (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .a(coef_word[l*HALF_W +: HALF_W]), .b(samp_word[l*HALF_W +: HALF_W]),
      .sgn(sgn_q), .prod_q(prod[l])
    );
    dotp_acc u_acc (
      .clk(clk), .rst_n(rst_n), .clr(start), .en(acc_en), .ext(ext_q), .sgn(sgn_q),
      .prod(prod[l]), .acc_q(acc[l]), .sat_evt(lane_sat[l])
    );
  end

  always_comb begin
    join_sat = sat_add(acc[0], acc[1]);
    join_val = ext_q ? join_sat.sum : wrap_add(acc[0], acc[1]);
    join_ovf = fin && ext_q && join_sat.ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      done     <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      done <= fin;
      if (fin) result <= join_val;
      if (start) sat_flag <= 1'b0;
      else       sat_flag <= sat_flag | (|lane_sat) | join_ovf;
    end
  end

  assign result_lo = result[HALF_W-1:0];

  // R10: saturation indicator is sticky until a new job
  a_r10_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !start) |=> sat_flag);
  // R8: a new job clears the indicator
  a_r8_start_clears_sat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sat_flag);
  // R10: saturation only appears in extended mode
  a_r10_sat_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> ext_q);
  // R6: result changes only together with done
  a_r6_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: tb/dotp_unit_bench.sv
module dotp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] count = '0;
  logic        signed_mode = 1'b0;
  logic        ext_mode = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] coef_word = '0;
  logic [31:0] samp_word = '0;
  logic        busy, done, sat_flag;
  logic [39:0] result;
  logic [15:0] result_lo;

  int n_chk = 0;
  int n_fail = 0;

  localparam longint LMAX = 64'sd549755813887;
  localparam longint LMIN = -64'sd549755813888;

  always #10 clk = ~clk;

  dotp_unit u_dotp_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .signed_mode(signed_mode), .ext_mode(ext_mode), .op_valid(op_valid),
    .coef_word(coef_word), .samp_word(samp_word), .busy(busy), .done(done),
    .result(result), .result_lo(result_lo), .sat_flag(sat_flag)
  );

  typedef struct packed {
    logic             sg;
    logic             ex;
    logic             gap;
    logic [2:0]       cnt;
    logic [3:0][31:0] c;
    logic [3:0][31:0] s;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{1'b1, 1'b0, 1'b0, 3'd2,
      {32'h0, 32'h0, 32'h0005_0004, 32'h0003_0002},
      {32'h0, 32'h0, 32'h0007_0006, 32'h0002_0001}},
    '{1'b1, 1'b0, 1'b1, 3'd4,
      {32'hFFFF_0002, 32'h8000_7FFF, 32'hFFF0_0010, 32'h0001_FFFE},
      {32'h0003_FFFD, 32'h0002_0002, 32'h0100_0100, 32'h1234_0005}},
    '{1'b0, 1'b0, 1'b0, 3'd3,
      {32'h0, 32'hFFFF_FFFF, 32'h8000_C000, 32'h1234_ABCD},
      {32'h0, 32'hFFFF_FFFF, 32'hFFFF_4000, 32'h00FF_FF00}},
    '{1'b1, 1'b1, 1'b0, 3'd4,
      {32'h7FFF_8000, 32'h8000_8000, 32'h7FFF_7FFF, 32'h8001_7FFF},
      {32'h7FFF_8000, 32'h8000_8000, 32'h7FFF_7FFF, 32'h8001_7FFF}},
    '{1'b0, 1'b1, 1'b1, 3'd1,
      {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF},
      {32'h0, 32'h0, 32'h0, 32'hFFFF_0001}},
    '{1'b1, 1'b0, 1'b0, 3'd3,
      {32'h0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_7FFF},
      {32'h0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_7FFF}}
  };

  longint me, mo;
  bit     msat;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint acc_step(longint a, longint p, bit ex);
    longint t;
    t = a + p;
    if (ex) begin
      if (t > LMAX) begin msat = 1'b1; return LMAX; end
      if (t < LMIN) begin msat = 1'b1; return LMIN; end
      return t;
    end
    return longint'(int'(t));
  endfunction

  task automatic model_pair(input logic [31:0] c, input logic [31:0] s, input bit sg, input bit ex);
    longint p0, p1;
    if (sg) begin
      p0 = longint'($signed(c[15:0]))  * longint'($signed(s[15:0]));
      p1 = longint'($signed(c[31:16])) * longint'($signed(s[31:16]));
    end else begin
      p0 = longint'(c[15:0])  * longint'(s[15:0]);
      p1 = longint'(c[31:16]) * longint'(s[31:16]);
    end
    me = acc_step(me, p0, ex);
    mo = acc_step(mo, p1, ex);
  endtask

  task automatic run_job(input bit sg, input bit ex, input int cnt, input bit gap,
                         input logic [3:0][31:0] c, input logic [3:0][31:0] s,
                         input string tag);
    longint exp;
    me = 0; mo = 0; msat = 1'b0;
    @(negedge clk);
    start = 1'b1; count = 16'(cnt); signed_mode = sg; ext_mode = ex; op_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      if (gap && i == 1) begin
        op_valid = 1'b0;
        @(negedge clk);
      end
      op_valid = 1'b1; coef_word = c[i % 4]; samp_word = s[i % 4];
      model_pair(c[i % 4], s[i % 4], sg, ex);
      @(negedge clk);
    end
    op_valid = 1'b0;
    exp = acc_step(me, mo, ex);
    if (cnt == 0) begin
      chk(done == 1'b0, {"R7 early done ", tag}, longint'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, {"R7 done ", tag}, longint'(done), 1);
      chk(result == 40'(exp), {"R7 result ", tag}, longint'(result), exp);
    end else begin
      chk(done == 1'b0, {"R6 done at +1 ", tag}, longint'(done), 0);
      @(negedge clk);
      chk(done == 1'b0, {"R6 done at +2 ", tag}, longint'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, {"R6 done at +3 ", tag}, longint'(done), 1);
      chk(result == 40'(exp), {"R2/R3 result ", tag}, longint'(result), exp);
      chk(result_lo == exp[15:0], {"R11 result_lo ", tag}, longint'(result_lo), longint'(exp[15:0]));
      chk(sat_flag == msat, {"R10 sat_flag ", tag}, longint'(sat_flag), longint'(msat));
    end
    @(negedge clk);
    chk(done == 1'b0, {"R6 pulse width ", tag}, longint'(done), 0);
    chk(busy == 1'b0, {"R6 busy ", tag}, longint'(busy), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [39:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1 done/busy in reset", longint'({done, busy}), 0);
    chk(result == '0 && sat_flag == 1'b0, "R1 result/sat in reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 after release", longint'(result), 0);

    // vector table: R2 R3 R5 R6 R9 R10 R11
    for (int k = 0; k < 6; k++)
      run_job(TBL[k].sg, TBL[k].ex, int'(TBL[k].cnt), TBL[k].gap, TBL[k].c, TBL[k].s,
              $sformatf("vec%0d", k));

    // R4: stuffed words after the job are ignored
    held = result;
    for (int i = 0; i < 3; i++) begin
      op_valid = 1'b1; coef_word = 32'h1111_2222; samp_word = 32'h3333_4444;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R4 extra word no done", longint'({done, busy}), 0);
    end
    op_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(result == held && done == 1'b0, "R4 result unchanged", longint'(result), longint'(held));

    // R7: count of zero
    run_job(1'b1, 1'b0, 0, 1'b0, '0, '0, "count0");

    // R10: positive saturation, unsigned, 140 pairs of all-ones
    run_job(1'b0, 1'b1, 140, 1'b0, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, "R10 pos sat");
    chk(result == 40'h7F_FFFF_FFFF, "R10 clamp high", longint'(result), LMAX);

    // R8: new job clears sat_flag
    run_job(1'b1, 1'b1, 1, 1'b0, {4{32'h0002_0003}}, {4{32'h0004_0005}}, "R8 sat cleared");

    // R10: negative saturation, signed, 600 pairs
    run_job(1'b1, 1'b1, 600, 1'b0, {4{32'h8000_8000}}, {4{32'h7FFF_7FFF}}, "R10 neg sat");
    chk(result == 40'h80_0000_0000, "R10 clamp low", longint'(result), LMIN);

    // R8: restart in the middle of a job
    @(negedge clk);
    start = 1'b1; count = 16'd3; signed_mode = 1'b1; ext_mode = 1'b0;
    @(negedge clk);
    start = 1'b0; op_valid = 1'b1; coef_word = 32'h7000_7000; samp_word = 32'h7000_7000;
    @(negedge clk);
    op_valid = 1'b0;
    run_job(1'b1, 1'b0, 1, 1'b0, {4{32'h0010_0001}}, {4{32'h0003_0009}}, "R8 restart");
    chk(result == 40'd57, "R8 restart value", longint'(result), 57);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule